// File: doc/BRIEF.md
# DMA Channel Control and Status Register Slice

This block holds the register slice of one channel of a descriptor-driven DMA engine. It sits on a simple 32-bit register bus and decodes a 0x100-byte channel window. The window holds a control/status word, the address of the descriptor in flight, working copies of the descriptor fields (transfer info, source, destination, length, stride, next-descriptor pointer) and a debug word that records error causes.

Software uses the control/status word to drive the channel. It can start the channel, pause it, abandon the descriptor in flight or return the channel to idle. The same word carries the sticky completion and interrupt flags, which software clears by writing 1 to them. The data mover itself is outside this block. It sees only a run level (`mv_go`), and it reports back through a completion strobe and an error strobe that carries a 3-bit cause code. When the descriptor in flight completes, the slice follows the next-descriptor pointer. A zero pointer ends the chain.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register in the window reads 0, and `irq` and `mv_go` are 0.
- R2: The descriptor-address, info, source, destination, length, stride and next registers sit at byte offsets 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. While the channel is not active, each reads back the last value written to it. Offsets that decode to nothing read 0.
- R3: Writing control/status (offset 0x00) with bit 0 = 1, and with bits 30 and 31 both 0, makes the channel active. From the next cycle, control/status bit 0 and `mv_go` read 1.
- R4: Writing control/status with bit 0 = 0 while the channel is active pauses it. Active drops, and the paused flag (bit 4) reads 1. Writing bit 0 = 1 later reactivates the channel and clears the paused flag.
- R5: A `mv_done` pulse while active sets the end flag (bit 1). It also sets the interrupt flag (bit 2) when info bit 0 is 1. The descriptor address then takes the value of the next register. Active stays set only if that value is nonzero.
- R6: Writing 1 to bit 1 or bit 2 of control/status clears that flag. Writing 0 to either bit leaves the flag unchanged. `irq` is high exactly while the interrupt flag is set.
- R7: Writing control/status with bit 30 = 1 (abort) drops the current descriptor. The descriptor address takes the value of the next register. The channel is active afterwards only if bit 0 was written 1 and that next value is nonzero. The paused flag clears.
- R8: Writing control/status with bit 31 = 1 (reset) clears the active, paused, end and interrupt flags, the descriptor address and the debug cause. Bits 30 and 31 of control/status always read 0.
- R9: A `mv_err` pulse ORs `mv_err_code` into debug bits 2:0 (offset 0x20) and stops the channel. Control/status bit 8 reads 1 whenever that cause is nonzero. Writing 1s to debug bits 2:0 clears those bits.
- R10: While the channel is active, writes to offsets 0x04 through 0x1C are ignored.
- R11: Control/status bits 28 and 29 are stored options. They read back the value last written by a control/status write that did not request reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mv_go | output | 1 | Channel active; the data mover may run |
| mv_done | input | 1 | Descriptor in flight completed |
| mv_err | input | 1 | Data mover error strobe |
| mv_err_code | input | 3 | Error cause that comes with `mv_err` |
| irq | output | 1 | Channel interrupt request |

## Verification
Every state bit in the slice is visible at the ports in the cycle after the event that changes it. A flag that is set or cleared wrongly shows up on `irq`, `mv_go` or the combinational read of control/status as soon as the next register read. The riskiest paths are the chain step on completion and on abort, where a wrong descriptor address or a wrong active decision depends on whether the next register is zero. Both the zero and the nonzero case are exercised for completion and for abort. The ignored-write rule is checked by reading the protected field back after an attempted write while the channel is active.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int ECW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           mv_go,
  input  logic           mv_done,
  input  logic           mv_err,
  input  logic [ECW-1:0] mv_err_code,
  output logic           irq
);
  localparam logic [AW-1:0] A_CS   = AW'('h00);
  localparam logic [AW-1:0] A_CB   = AW'('h04);
  localparam logic [AW-1:0] A_INFO = AW'('h08);
  localparam logic [AW-1:0] A_SRC  = AW'('h0C);
  localparam logic [AW-1:0] A_DST  = AW'('h10);
  localparam logic [AW-1:0] A_LEN  = AW'('h14);
  localparam logic [AW-1:0] A_STRD = AW'('h18);
  localparam logic [AW-1:0] A_NXT  = AW'('h1C);
  localparam logic [AW-1:0] A_DBG  = AW'('h20);

  logic act, psd, endf, intf;
  logic [1:0] opt;
  logic [DW-1:0] cb_q, info_q, src_q, dst_q, len_q, strd_q, nxt_q;
  logic [ECW-1:0] dbg_q, dbg_clr;

  wire csw   = bus_wr && (bus_addr == A_CS);
  wire rstc  = csw && bus_wdata[31];
  wire abtc  = csw && bus_wdata[30];
  wire dn    = mv_done && act;
  wire fw    = bus_wr && !act;
  wire nxt_z = (nxt_q == '0);

  assign dbg_clr = (bus_wr && bus_addr == A_DBG) ? bus_wdata[ECW-1:0] : '0;
  assign mv_go   = act;
  assign irq     = intf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; psd <= 1'b0; endf <= 1'b0; intf <= 1'b0; opt <= '0;
      cb_q <= '0; info_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; strd_q <= '0; nxt_q <= '0; dbg_q <= '0;
    end else begin
      if (fw) begin
        case (bus_addr)
          A_CB:    cb_q   <= bus_wdata;
          A_INFO:  info_q <= bus_wdata;
          A_SRC:   src_q  <= bus_wdata;
          A_DST:   dst_q  <= bus_wdata;
          A_LEN:   len_q  <= bus_wdata;
          A_STRD:  strd_q <= bus_wdata;
          A_NXT:   nxt_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (rstc) begin
        act <= 1'b0; psd <= 1'b0; endf <= 1'b0; intf <= 1'b0;
        cb_q <= '0; dbg_q <= '0;
      end else begin
        endf  <= (endf & ~(csw & bus_wdata[1])) | dn;
        intf  <= (intf & ~(csw & bus_wdata[2])) | (dn & info_q[0]);
        dbg_q <= (dbg_q & ~dbg_clr) | (mv_err ? mv_err_code : '0);
        if (csw) opt <= bus_wdata[29:28];
        if (mv_err) begin
          act <= 1'b0;
        end else if (abtc) begin
          cb_q <= nxt_q;
          act  <= bus_wdata[0] && !nxt_z;
          psd  <= 1'b0;
        end else if (csw) begin
          act <= bus_wdata[0];
          if (bus_wdata[0]) psd <= 1'b0;
          else if (act)     psd <= 1'b1;
        end else if (dn) begin
          cb_q <= nxt_q;
          act  <= !nxt_z;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CS: begin
        bus_rdata[0]     = act;
        bus_rdata[1]     = endf;
        bus_rdata[2]     = intf;
        bus_rdata[4]     = psd;
        bus_rdata[8]     = |dbg_q;
        bus_rdata[29:28] = opt;
      end
      A_CB:    bus_rdata = cb_q;
      A_INFO:  bus_rdata = info_q;
      A_SRC:   bus_rdata = src_q;
      A_DST:   bus_rdata = dst_q;
      A_LEN:   bus_rdata = len_q;
      A_STRD:  bus_rdata = strd_q;
      A_NXT:   bus_rdata = nxt_q;
      A_DBG:   bus_rdata[ECW-1:0] = dbg_q;
      default: bus_rdata = '0;
    endcase
  end

  // R8
  rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rstc |=> !mv_go && !irq && dbg_q == '0);

  // R4
  pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csw && act && !bus_wdata[0] && !bus_wdata[30] && !bus_wdata[31] && !mv_err
    |=> !mv_go && psd);

  // R10
  frozen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && act && bus_addr == A_SRC |=> $stable(src_q));

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_err && mv_err_code != '0 && !rstc |=> dbg_q != '0 && !mv_go);

  // R6
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csw && bus_wdata[2] && !dn |=> !irq);

  // R5
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn && nxt_z && !bus_wr && !mv_err |=> !mv_go && endf && cb_q == '0);
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mv_go, irq;
  logic mv_done = 1'b0, mv_err = 1'b0;
  logic [2:0] mv_err_code = '0;
  int vectors = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mv_go(mv_go),
    .mv_done(mv_done), .mv_err(mv_err), .mv_err_code(mv_err_code), .irq(irq));

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); mv_done = 1'b1;
    @(negedge clk); mv_done = 1'b0;
  endtask

  task automatic pulse_err(input logic [2:0] c);
    @(negedge clk); mv_err = 1'b1; mv_err_code = c;
    @(negedge clk); mv_err = 1'b0; mv_err_code = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr %02h: got %08h expected %08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic pin(input string req, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s pin: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic t_reset();
    for (int a = 0; a <= 'h20; a += 4) rd("R1", 8'(a), 32'h0);
    pin("R1 irq", irq, 1'b0);
    pin("R1 go", mv_go, 1'b0);
  endtask

  task automatic t_fields();
    wr(8'h04, 32'h0000_3000);
    wr(8'h08, 32'h0000_0001);
    wr(8'h0C, 32'h0000_1000);
    wr(8'h10, 32'h0000_2000);
    wr(8'h14, 32'h0000_0040);
    wr(8'h18, 32'h0008_0004);
    wr(8'h1C, 32'h0000_5000);
    rd("R2 cb", 8'h04, 32'h0000_3000);
    rd("R2 info", 8'h08, 32'h0000_0001);
    rd("R2 src", 8'h0C, 32'h0000_1000);
    rd("R2 dst", 8'h10, 32'h0000_2000);
    rd("R2 len", 8'h14, 32'h0000_0040);
    rd("R2 stride", 8'h18, 32'h0008_0004);
    rd("R2 next", 8'h1C, 32'h0000_5000);
    rd("R2 hole", 8'h24, 32'h0);
  endtask

  task automatic t_options();
    wr(8'h00, 32'h3000_0000);
    rd("R11 set", 8'h00, 32'h3000_0000);
    wr(8'h00, 32'h1000_0000);
    rd("R11 partial", 8'h00, 32'h1000_0000);
    wr(8'h00, 32'h0);
    rd("R11 clear", 8'h00, 32'h0);
  endtask

  task automatic t_activate();
    wr(8'h00, 32'h1);
    rd("R3 cs", 8'h00, 32'h1);
    pin("R3 go", mv_go, 1'b1);
    wr(8'h0C, 32'h0000_DEAD);
    rd("R10 src", 8'h0C, 32'h0000_1000);
    wr(8'h1C, 32'h0000_0000);
    rd("R10 next", 8'h1C, 32'h0000_5000);
  endtask

  task automatic t_done_chain();
    pulse_done();
    rd("R5 cs", 8'h00, 32'h7);
    rd("R5 cb", 8'h04, 32'h0000_5000);
    pin("R5 irq", irq, 1'b1);
    wr(8'h00, 32'h1);
    rd("R6 zero-write keeps", 8'h00, 32'h7);
    wr(8'h00, 32'h7);
    rd("R6 w1c", 8'h00, 32'h1);
    pin("R6 irq", irq, 1'b0);
  endtask

  task automatic t_pause_abort();
    wr(8'h00, 32'h0);
    rd("R4 paused", 8'h00, 32'h10);
    pin("R4 go", mv_go, 1'b0);
    wr(8'h00, 32'h1);
    rd("R4 resume", 8'h00, 32'h1);
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h0);
    rd("R10 next writable when paused", 8'h1C, 32'h0);
    wr(8'h00, 32'h4000_0007);
    rd("R7 abort end", 8'h00, 32'h0);
    rd("R7 cb", 8'h04, 32'h0);
    wr(8'h1C, 32'h0000_6000);
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h4000_0001);
    rd("R7 abort step", 8'h00, 32'h1);
    rd("R7 cb step", 8'h04, 32'h0000_6000);
  endtask

  task automatic t_chain_end();
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h00, 32'h1);
    pulse_done();
    rd("R5 last", 8'h00, 32'h6);
    rd("R5 cb zero", 8'h04, 32'h0);
    pin("R5 go", mv_go, 1'b0);
    wr(8'h00, 32'h6);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1);
    pulse_done();
    rd("R5 no int", 8'h00, 32'h2);
    pin("R5 irq off", irq, 1'b0);
    wr(8'h00, 32'h2);
  endtask

  task automatic t_error();
    wr(8'h00, 32'h1);
    pulse_err(3'b101);
    rd("R9 cs", 8'h00, 32'h100);
    rd("R9 dbg", 8'h20, 32'h5);
    pin("R9 go", mv_go, 1'b0);
    wr(8'h20, 32'h1);
    rd("R9 partial", 8'h20, 32'h4);
    rd("R9 cs still", 8'h00, 32'h100);
    wr(8'h20, 32'h4);
    rd("R9 cleared", 8'h00, 32'h0);
  endtask

  task automatic t_reset_cmd();
    wr(8'h08, 32'h1);
    wr(8'h1C, 32'h0000_7000);
    wr(8'h00, 32'h1);
    pulse_done();
    pulse_err(3'b010);
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h8000_0000);
    rd("R8 cs", 8'h00, 32'h0);
    rd("R8 cb", 8'h04, 32'h0);
    rd("R8 dbg", 8'h20, 32'h0);
    pin("R8 irq", irq, 1'b0);
    pin("R8 go", mv_go, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_options();
    t_activate();
    t_done_chain();
    t_pause_abort();
    t_chain_end();
    t_error();
    t_reset_cmd();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule